// File: doc/BRIEF.md
# DDR2 Write Burst Scheduler

This block sits on the controller side of a DDR2 SDRAM interface. It accepts a write request carrying a bank, a starting column and a whole burst of data words. It then issues the write command on the command pins and counts the write latency from the configured additive and CAS latencies. It drives the data strobe through a one-clock low preamble, the data beats and a half-clock postamble, and then releases the bus. After the burst it also holds back any precharge to the written bank until the write-recovery count has run out.

The strobe and data lanes are shown at clock rate with two values per clock. `dqRise` and `dqFall` carry the words for the first half and the second half of the clock. `dqs` carries the strobe level in each half (bit 0 is the first half) and `dqsOe` carries the strobe output enable in each half. A beat has the strobe high in the first half and low in the second, so one word goes out on each strobe edge.

Top module: `ddr2_wr_sched`

## Requirements
- R1: During and right after reset the command pins show NOP ({csN,rasN,casN,weN} = 0111), `dqOe` is 0, `dqsOe` is 00, and `reqReady` and `preReady` are 1.
- R2: A write accepted on a clock edge (`reqValid` and `reqReady` both high) appears in the following cycle as {csN,rasN,casN,weN} = 0100, with `bankOut` set to the request bank and `addrOut` set to the column zero-extended. Every cycle with no command shows NOP (0111).
- R3: Take the cycle that shows the write command as cycle 0, and let WL = cfgAl + cfgCl − 1. The first data cycle is cycle WL.
- R4: Cycle WL−1 is the preamble: `dqsOe` = 11, `dqs` = 00, `dqOe` = 0.
- R5: In data cycle WL+b, `dqRise` carries word 2b and `dqFall` carries word 2b+1, where word i is bits [8i+7:8i] of `reqData`. In these cycles `dqs` = 01, `dqsOe` = 11 and `dqOe` = 1.
- R6: `cfgBl8` = 1 gives a burst of 8 words (4 data cycles). `cfgBl8` = 0 gives 4 words (2 data cycles), and words 4 to 7 are never driven.
- R7: The burst words are captured when the request is accepted. Changes to `reqData` after that have no effect on the burst.
- R8: The cycle after the last data cycle is the postamble (`dqsOe` = 01, `dqs` = 00, `dqOe` = 0). After it both output enables are 0.
- R9: With cfgWr in 2..15 and K = WL + BL/2 + cfgWr − 1, `preReady` for the written bank is low from cycle 0 to cycle K−1 and high from cycle K. An accepted precharge appears in the next cycle as 0010, with the bank on `bankOut` and `addrOut` = 0.
- R10: A precharge to a different bank is accepted while the burst is in flight.
- R11: `reqReady` is low from cycle 0 to cycle K−1 and high again from cycle K.
- R12: In a cycle where a write is being accepted, `preReady` is 0, so at most one command goes out per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgAl | input | 3 | Additive latency in clocks (0..5) |
| cfgCl | input | 3 | CAS latency in clocks (3..6) |
| cfgBl8 | input | 1 | 1: burst of 8, 0: burst of 4 |
| cfgWr | input | 4 | Write-recovery clocks (2..15) |
| reqValid | input | 1 | Write request valid |
| reqReady | output | 1 | Write request accepted when high with reqValid |
| reqBank | input | BANK_W | Write bank |
| reqCol | input | COL_W | Starting column |
| reqData | input | MAX_BL*DATA_W | Burst words, word 0 in the low bits |
| preValid | input | 1 | Precharge request valid |
| preReady | output | 1 | Precharge accepted when high with preValid |
| preBank | input | BANK_W | Bank to precharge |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| bankOut | output | BANK_W | Bank address pins |
| addrOut | output | ADDR_W | Address pins |
| dqRise | output | DATA_W | Data word on the rising strobe edge |
| dqFall | output | DATA_W | Data word on the falling strobe edge |
| dqOe | output | 1 | Data lane output enable |
| dqs | output | 2 | Strobe level per half clock |
| dqsOe | output | 2 | Strobe output enable per half clock |

## Verification
The hardest case is the precharge gate. The exact release cycle depends on three settings at once, and a different-bank precharge must get through in the middle of the same burst. The stimulus sweeps every combination of additive latency 0..3, CAS latency 3..5, both burst lengths and recovery 2..4. In each run a precharge to another bank is raised while the burst is still waiting, and then one to the written bank is held from early on so that the first cycle it is accepted can be compared with the computed release point. Each run also raises both requests together in the accepting cycle and scrambles the data input right after acceptance.

// File: rtl/ddr2_wr_pkg.sv
package ddr2_wr_pkg;

  // beat index width; covers up to 8 beats per burst
  localparam int IDX_W = 3;

  // command pin patterns ordered {csN, rasN, casN, weN}
  localparam logic [3:0] CMD_NOP   = 4'b0111;
  localparam logic [3:0] CMD_WRITE = 4'b0100;
  localparam logic [3:0] CMD_PRE   = 4'b0010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_PRE,
    ST_DATA,
    ST_POST
  } seqState_t;

  // strobes from control to datapath, describing the next cycle
  typedef struct packed {
    logic             wrCmd;
    logic             preCmd;
    logic             preamble;
    logic             beatOn;
    logic             postamble;
    logic [IDX_W-1:0] beatIdx;
  } dpCtl_t;

endpackage

// File: rtl/ddr2_wr_ctrl.sv
module ddr2_wr_ctrl
  import ddr2_wr_pkg::*;
#(
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cfgAl,
  input  logic [2:0]        cfgCl,
  input  logic              cfgBl8,
  input  logic [3:0]        cfgWr,
  input  logic              reqValid,
  input  logic [BANK_W-1:0] reqBank,
  input  logic              preValid,
  input  logic [BANK_W-1:0] preBank,
  output logic              reqReady,
  output logic              preReady,
  output dpCtl_t            ctl
);

  seqState_t        state, stateN;
  logic [3:0]       latCnt, latCntN;
  logic [IDX_W-1:0] beat, beatN;
  logic [3:0]       recCnt, recCntN;
  logic [BANK_W-1:0] recBank;

  logic [3:0]       writeLat;
  logic [IDX_W-1:0] lastBeat;
  logic             wrAccept;
  logic             preAccept;
  logic             bankHeld;

  assign writeLat = 4'(cfgAl) + 4'(cfgCl) - 4'd1;
  assign lastBeat = cfgBl8 ? IDX_W'(3) : IDX_W'(1);

  assign reqReady  = (state == ST_IDLE) && (recCnt <= 4'd1);
  assign wrAccept  = reqValid && reqReady;
  assign bankHeld  = ((state != ST_IDLE) || (recCnt > 4'd1)) && (preBank == recBank);
  assign preReady  = !bankHeld && !wrAccept;
  assign preAccept = preValid && preReady;

  always_comb begin
    stateN  = state;
    latCntN = latCnt;
    beatN   = beat;
    case (state)
      ST_IDLE: begin
        if (wrAccept) begin
          stateN  = ST_WAIT;
          latCntN = writeLat - 4'd2;
        end
      end
      ST_WAIT: begin
        if (latCnt == 4'd0) stateN = ST_PRE;
        else                latCntN = latCnt - 4'd1;
      end
      ST_PRE: begin
        stateN = ST_DATA;
        beatN  = '0;
      end
      ST_DATA: begin
        if (beat == lastBeat) stateN = ST_POST;
        else                  beatN  = beat + IDX_W'(1);
      end
      ST_POST: stateN = ST_IDLE;
      default: stateN = ST_IDLE;
    endcase
  end

  always_comb begin
    if (state == ST_DATA && beat == lastBeat) recCntN = cfgWr;
    else if (recCnt != 4'd0)                  recCntN = recCnt - 4'd1;
    else                                      recCntN = recCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      latCnt  <= '0;
      beat    <= '0;
      recCnt  <= '0;
      recBank <= '0;
    end else begin
      state  <= stateN;
      latCnt <= latCntN;
      beat   <= beatN;
      recCnt <= recCntN;
      if (wrAccept) recBank <= reqBank;
    end
  end

  always_comb begin
    ctl.wrCmd     = wrAccept;
    ctl.preCmd    = preAccept;
    ctl.preamble  = (stateN == ST_PRE);
    ctl.beatOn    = (stateN == ST_DATA);
    ctl.postamble = (stateN == ST_POST);
    ctl.beatIdx   = beatN;
  end

endmodule

// File: rtl/ddr2_wr_dp.sv
module ddr2_wr_dp
  import ddr2_wr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BANK_W = 3,
  parameter int COL_W  = 10,
  parameter int ADDR_W = 14,
  parameter int MAX_BL = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpCtl_t                   ctl,
  input  logic [BANK_W-1:0]        reqBank,
  input  logic [COL_W-1:0]         reqCol,
  input  logic [MAX_BL*DATA_W-1:0] reqData,
  input  logic [BANK_W-1:0]        preBank,
  output logic                     csN,
  output logic                     rasN,
  output logic                     casN,
  output logic                     weN,
  output logic [BANK_W-1:0]        bankOut,
  output logic [ADDR_W-1:0]        addrOut,
  output logic [DATA_W-1:0]        dqRise,
  output logic [DATA_W-1:0]        dqFall,
  output logic                     dqOe,
  output logic [1:0]               dqs,
  output logic [1:0]               dqsOe
);

  localparam int WIDX_W = $clog2(MAX_BL);

  logic [DATA_W-1:0] inWord [MAX_BL];
  logic [DATA_W-1:0] heldWord [MAX_BL];
  logic [WIDX_W-1:0] riseIdx;
  logic [WIDX_W-1:0] fallIdx;

  for (genvar g = 0; g < MAX_BL; g++) begin : gWord
    assign inWord[g] = reqData[g*DATA_W +: DATA_W];
    always_ff @(posedge clk) begin
      if (!rstN)          heldWord[g] <= '0;
      else if (ctl.wrCmd) heldWord[g] <= inWord[g];
    end
  end

  assign riseIdx = WIDX_W'({ctl.beatIdx, 1'b0});
  assign fallIdx = riseIdx | WIDX_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {csN, rasN, casN, weN} <= CMD_NOP;
      bankOut <= '0;
      addrOut <= '0;
    end else if (ctl.wrCmd) begin
      {csN, rasN, casN, weN} <= CMD_WRITE;
      bankOut <= reqBank;
      addrOut <= ADDR_W'(reqCol);
    end else if (ctl.preCmd) begin
      {csN, rasN, casN, weN} <= CMD_PRE;
      bankOut <= preBank;
      addrOut <= '0;
    end else begin
      {csN, rasN, casN, weN} <= CMD_NOP;
      bankOut <= '0;
      addrOut <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dqRise <= '0;
      dqFall <= '0;
      dqOe   <= 1'b0;
      dqs    <= 2'b00;
      dqsOe  <= 2'b00;
    end else begin
      dqOe <= ctl.beatOn;
      if (ctl.beatOn) begin
        dqRise <= heldWord[riseIdx];
        dqFall <= heldWord[fallIdx];
        dqs    <= 2'b01;
        dqsOe  <= 2'b11;
      end else if (ctl.preamble) begin
        dqs    <= 2'b00;
        dqsOe  <= 2'b11;
      end else if (ctl.postamble) begin
        dqs    <= 2'b00;
        dqsOe  <= 2'b01;
      end else begin
        dqs    <= 2'b00;
        dqsOe  <= 2'b00;
      end
    end
  end

endmodule

// File: rtl/ddr2_wr_sched.sv
module ddr2_wr_sched
  import ddr2_wr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BANK_W = 3,
  parameter int COL_W  = 10,
  parameter int ADDR_W = 14,
  parameter int MAX_BL = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [2:0]               cfgAl,
  input  logic [2:0]               cfgCl,
  input  logic                     cfgBl8,
  input  logic [3:0]               cfgWr,
  input  logic                     reqValid,
  output logic                     reqReady,
  input  logic [BANK_W-1:0]        reqBank,
  input  logic [COL_W-1:0]         reqCol,
  input  logic [MAX_BL*DATA_W-1:0] reqData,
  input  logic                     preValid,
  output logic                     preReady,
  input  logic [BANK_W-1:0]        preBank,
  output logic                     csN,
  output logic                     rasN,
  output logic                     casN,
  output logic                     weN,
  output logic [BANK_W-1:0]        bankOut,
  output logic [ADDR_W-1:0]        addrOut,
  output logic [DATA_W-1:0]        dqRise,
  output logic [DATA_W-1:0]        dqFall,
  output logic                     dqOe,
  output logic [1:0]               dqs,
  output logic [1:0]               dqsOe
);

  dpCtl_t ctl;

  ddr2_wr_ctrl #(.BANK_W(BANK_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgAl    (cfgAl),
    .cfgCl    (cfgCl),
    .cfgBl8   (cfgBl8),
    .cfgWr    (cfgWr),
    .reqValid (reqValid),
    .reqBank  (reqBank),
    .preValid (preValid),
    .preBank  (preBank),
    .reqReady (reqReady),
    .preReady (preReady),
    .ctl      (ctl)
  );

  ddr2_wr_dp #(
    .DATA_W (DATA_W),
    .BANK_W (BANK_W),
    .COL_W  (COL_W),
    .ADDR_W (ADDR_W),
    .MAX_BL (MAX_BL)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .reqBank (reqBank),
    .reqCol  (reqCol),
    .reqData (reqData),
    .preBank (preBank),
    .csN     (csN),
    .rasN    (rasN),
    .casN    (casN),
    .weN     (weN),
    .bankOut (bankOut),
    .addrOut (addrOut),
    .dqRise  (dqRise),
    .dqFall  (dqFall),
    .dqOe    (dqOe),
    .dqs     (dqs),
    .dqsOe   (dqsOe)
  );

endmodule

// File: rtl/ddr2_wr_sched_chk.sv
module ddr2_wr_sched_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       reqReady,
  input logic       preReady,
  input logic       csN,
  input logic       rasN,
  input logic       casN,
  input logic       weN,
  input logic       dqOe,
  input logic [1:0] dqs,
  input logic [1:0] dqsOe
);

  // R2
  cmd_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    ({csN, rasN, casN, weN} == 4'b0111) || ({csN, rasN, casN, weN} == 4'b0100) ||
    ({csN, rasN, casN, weN} == 4'b0010));

  // R2
  wr_cmd_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    ({csN, rasN, casN, weN} == 4'b0100) |-> $past(reqValid && reqReady));

  // R4
  preamble_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dqOe) |-> ($past(dqsOe) == 2'b11 && $past(dqs) == 2'b00));

  // R5
  beat_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> (dqsOe == 2'b11 && dqs == 2'b01));

  // R8
  postamble_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dqOe) |-> (dqsOe == 2'b01 && dqs == 2'b00));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dqsOe == 2'b01) |=> (dqsOe == 2'b00));

  // R11
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dqsOe != 2'b00) |-> !reqReady);

  // R12
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |-> !preReady);

endmodule

bind ddr2_wr_sched ddr2_wr_sched_chk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .preReady (preReady),
  .csN      (csN),
  .rasN     (rasN),
  .casN     (casN),
  .weN      (weN),
  .dqOe     (dqOe),
  .dqs      (dqs),
  .dqsOe    (dqsOe)
);

// File: tb/ddr2_wr_sched_test.sv
module ddr2_wr_sched_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  cfgAl = 3'd0;
  logic [2:0]  cfgCl = 3'd3;
  logic        cfgBl8 = 1'b0;
  logic [3:0]  cfgWr = 4'd2;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [2:0]  reqBank = '0;
  logic [9:0]  reqCol = '0;
  logic [63:0] reqData = '0;
  logic        preValid = 1'b0;
  logic        preReady;
  logic [2:0]  preBank = '0;
  logic        csN, rasN, casN, weN;
  logic [2:0]  bankOut;
  logic [13:0] addrOut;
  logic [7:0]  dqRise, dqFall;
  logic        dqOe;
  logic [1:0]  dqs, dqsOe;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ddr2_wr_sched uut (
    .clk(clk), .rstN(rstN), .cfgAl(cfgAl), .cfgCl(cfgCl), .cfgBl8(cfgBl8),
    .cfgWr(cfgWr), .reqValid(reqValid), .reqReady(reqReady), .reqBank(reqBank),
    .reqCol(reqCol), .reqData(reqData), .preValid(preValid), .preReady(preReady),
    .preBank(preBank), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .bankOut(bankOut), .addrOut(addrOut), .dqRise(dqRise), .dqFall(dqFall),
    .dqOe(dqOe), .dqs(dqs), .dqsOe(dqsOe)
  );

  task automatic chk(bit ok, string tag, longint act, longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s at %0t: actual 0x%0h expected 0x%0h", tag, $time, act, exp);
    end
  endtask

  task automatic chkCmd(logic [3:0] expCode, logic [2:0] expBank, logic [13:0] expAddr, string tag);
    logic [3:0] code;
    code = {csN, rasN, casN, weN};
    chk(code == expCode, tag, code, expCode);
    chk(bankOut == expBank, tag, bankOut, expBank);
    chk(addrOut == expAddr, tag, addrOut, expAddr);
  endtask

  task automatic runOne(int al, int cl, bit bl8, int twr, int n);
    int wl;
    int beats;
    int relC;
    logic [7:0] w [8];
    logic [2:0] bnk;
    logic [2:0] oth;
    logic [9:0] col;
    wl = al + cl - 1;
    beats = bl8 ? 4 : 2;
    relC = wl + beats + twr - 1;
    bnk = 3'(n % 8);
    oth = 3'((n + 3) % 8);
    col = 10'((n * 37 + 5) % 1024);
    for (int i = 0; i < 8; i++) w[i] = 8'(n * 16 + i * 7 + 3);

    @(negedge clk);
    cfgAl = 3'(al); cfgCl = 3'(cl); cfgBl8 = bl8; cfgWr = 4'(twr);
    reqBank = bnk; reqCol = col;
    for (int i = 0; i < 8; i++) reqData[i*8 +: 8] = w[i];
    reqValid = 1'b1;
    preValid = 1'b1;
    preBank = oth;
    #1;
    chk(reqReady == 1'b1, "R11 idle ready", reqReady, 1);
    // R12: write accepted this cycle, precharge must be refused
    chk(preReady == 1'b0, "R12 write priority", preReady, 0);

    for (int c = 0; c <= relC + 1; c++) begin
      @(negedge clk);
      // command pins
      if (c == 0)             chkCmd(4'b0100, bnk, 14'(col), "R2 write cmd");
      else if (c == 2)        chkCmd(4'b0010, oth, 14'd0, "R10 other-bank precharge");
      else if (c == relC + 1) chkCmd(4'b0010, bnk, 14'd0, "R9 precharge after recovery");
      else                    chkCmd(4'b0111, 3'd0, 14'd0, "R2 nop");

      // strobe and data lanes
      begin
        bit expOe;
        logic [1:0] expDqsOe;
        expOe = (c >= wl) && (c < wl + beats);
        if (c == wl - 1 || expOe) expDqsOe = 2'b11;
        else if (c == wl + beats) expDqsOe = 2'b01;
        else                      expDqsOe = 2'b00;
        if (c == wl - 1) begin
          chk(dqsOe == 2'b11 && dqs == 2'b00 && !dqOe, "R4 preamble", {dqOe, dqsOe, dqs}, 5'b01100);
        end else if (expOe) begin
          chk(dqOe == 1'b1, "R3 data at WL", dqOe, 1);
          chk(dqs == 2'b01 && dqsOe == 2'b11, "R5 beat strobe", {dqsOe, dqs}, 4'b1101);
          chk(dqRise == w[2*(c-wl)], "R5 R7 rise word", dqRise, w[2*(c-wl)]);
          chk(dqFall == w[2*(c-wl)+1], "R5 R7 fall word", dqFall, w[2*(c-wl)+1]);
        end else if (c == wl + beats) begin
          chk(dqsOe == 2'b01 && dqs == 2'b00 && !dqOe, "R8 R6 postamble", {dqOe, dqsOe, dqs}, 5'b00100);
        end else begin
          chk(dqOe == expOe && dqsOe == expDqsOe, "R8 R6 bus released", {dqOe, dqsOe}, {expOe, expDqsOe});
        end
      end

      // stimulus for the next edge
      if (c == 0) begin
        reqValid = 1'b0;
        reqData = ~reqData ^ 64'h5a5a_1234_9876_c3c3;  // R7 scramble
        preValid = 1'b0;
      end else if (c == 1) begin
        preValid = 1'b1;
        preBank = oth;
      end else if (c == 2) begin
        preBank = bnk;
      end else if (c == relC + 1) begin
        preValid = 1'b0;
      end
      #1;
      if (c == 1) chk(preReady == 1'b1, "R10 other bank ready", preReady, 1);
      else if (c >= 2 && c <= relC)
        chk(preReady == (c >= relC), "R9 precharge gate", preReady, (c >= relC));
      if (c >= 1)
        chk(reqReady == (c >= relC), "R11 request gate", reqReady, (c >= relC));
    end
  endtask

  initial begin
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset values
    chkCmd(4'b0111, 3'd0, 14'd0, "R1 reset cmd");
    chk(dqOe == 1'b0 && dqsOe == 2'b00, "R1 reset enables", {dqOe, dqsOe}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chkCmd(4'b0111, 3'd0, 14'd0, "R1 cmd after reset");
    chk(dqOe == 1'b0 && dqsOe == 2'b00, "R1 enables after reset", {dqOe, dqsOe}, 0);
    chk(reqReady == 1'b1 && preReady == 1'b1, "R1 ready after reset", {reqReady, preReady}, 2'b11);

    begin
      int n;
      n = 0;
      for (int al = 0; al <= 3; al++)
        for (int cl = 3; cl <= 5; cl++)
          for (int b = 0; b <= 1; b++)
            for (int twr = 2; twr <= 4; twr++) begin
              runOne(al, cl, b[0], twr, n);
              n++;
            end
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule